// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Register Block

This block gives software a register view of a small one-time-programmable fuse array. A 32-bit register bus reaches a control word, a timing word and a program-data word. Each fuse row has a read-only shadow word in a window of its own. Software picks a row and arms a burn by writing a 16-bit unlock key into the control word. It then writes the program data, and that write starts the burn. The controller stays busy for a number of cycles set by the timing word, then ORs the data into the fuse row. A fuse bit can only go from 0 to 1.

The shadow words are not touched by a burn. Software refreshes them from the fuse array with a reload command, which also holds the busy flag for a short, timed interval. Build-time masks mark rows as read-locked or write-locked. A shadow read of a read-locked row returns a poison word and raises the error flag. An armed burn aimed at a write-locked row, or at a row past the end of the array, raises the error flag and leaves every fuse as it was.

The fuse array resets to all zeros. Analog fuse behaviour and clock gating are not modelled.

Top module: `fuse_regif`

## Requirements
- R1: After reset the control word reads 0x00000000 and every shadow word reads 0x00000000.
- R2: The control word is at 0x000, with row in bits 7:0, busy in bit 8, error in bit 9 and reload in bit 10. A write to 0x000 loads row and reload. A write to 0x004 ORs the written row and reload bits in. A write to 0x008 clears the written row bits and clears error when bit 9 is written as 1. Error can be cleared only through 0x008 and is never set by a write. Bits 31:16 read as zero.
- R3: The timing word is at 0x010, with program strobe P in bits 11:0, relax R in bits 15:12 and read strobe S in bits 21:16. A write replaces bits 21:0 only. Bits 27:22 keep their value and bits 31:28 read as zero. The reset value is 0x05431008 (P=8, R=1, S=3, bits 27:22 = 0x15).
- R4: A write to 0x000 with 0x3E77 in bits 31:16 arms a burn. Any other write to 0x000 disarms it. A write to 0x020 while armed starts a burn on the row held in control bits 7:0, and that write disarms. A write to 0x020 while not armed does not start a burn.
- R5: A burn holds busy high for P + 2*R + 1 cycles, starting the cycle after the data write.
- R6: When a burn ends, the fuse row becomes its old value ORed with the data, so bits are never cleared. Shadow words keep their old value until a reload, including in the cycle the burn commits.
- R7: Writing control bit 10 as 1 at 0x000 or 0x004 while idle starts a reload. Busy and reload both read 1 for S + 1 cycles, then both clear, and every shadow word then equals its fuse row.
- R8: Shadow row n is read at 0x400 + 0x10*n. A read of a read-locked row returns 0xBADABADA and sets error.
- R9: An armed data write to a write-locked row, or to a row at or beyond the row count, sets error. It leaves busy low and the fuses unchanged, and it still uses up the key.
- R10: While busy is high, a write to 0x000, 0x004, 0x008, 0x010 or 0x020 changes nothing and sets error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 13 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used for the side effects of a locked shadow read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of bus_addr |

## Verification
Two functions can fall in the same cycle: a burn committing its data into a fuse row, and a shadow read of that same row. The bench starts a burn on a row whose shadow is zero and reads that row's shadow every cycle, from the launch to past the commit edge. Every read must return the pre-burn value. Only a later reload may make the new bits visible. A timing write placed inside the same burn window must leave the timing word unchanged and must raise the error flag.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  localparam int CNT_W = 13;

  localparam logic [15:0] OFS_CTRL   = 16'h0000;
  localparam logic [15:0] OFS_SET    = 16'h0004;
  localparam logic [15:0] OFS_CLR    = 16'h0008;
  localparam logic [15:0] OFS_TIMING = 16'h0010;
  localparam logic [15:0] OFS_DATA   = 16'h0020;
  localparam logic [15:0] OFS_SHADOW = 16'h0400;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam logic [31:0] POISON     = 32'hBADA_BADA;

  localparam int BIT_BUSY   = 8;
  localparam int BIT_ERR    = 9;
  localparam int BIT_RELOAD = 10;

  // Cycles a burn keeps busy high: P + 2*R + 1
  function automatic logic [CNT_W-1:0] burn_len(input logic [11:0] prog,
                                                input logic [3:0]  relax);
    return CNT_W'(prog) + CNT_W'({relax, 1'b0}) + CNT_W'(1);
  endfunction

  // Cycles a reload keeps busy high: S + 1
  function automatic logic [CNT_W-1:0] reload_len(input logic [5:0] rstb);
    return CNT_W'(rstb) + CNT_W'(1);
  endfunction

  // Timing write: take the three strobe fields from the bus, keep bits 27:22
  function automatic logic [27:0] timing_merge(input logic [27:0] old_v,
                                               input logic [31:0] wdata);
    return {old_v[27:22], wdata[21:0]};
  endfunction

endpackage

// File: rtl/fuse_seq.sv
module fuse_seq #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= len - CNT_W'(1);
      end
    end else if (cnt_q == '0) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done = busy && (cnt_q == '0);

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);  // R10
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (len != '0));  // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);  // R5

endmodule

// File: rtl/fuse_store.sv
module fuse_store #(
  parameter int              ROWS    = 16,
  parameter logic [ROWS-1:0] RD_LOCK = '0,
  parameter logic [ROWS-1:0] WR_LOCK = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        burn_en,
  input  logic [7:0]  burn_row,
  input  logic [31:0] burn_data,
  input  logic        reload_en,
  input  logic [7:0]  prog_row,
  output logic        prog_ok,
  input  logic [7:0]  rd_row,
  output logic [31:0] rd_word,
  output logic        rd_locked
);

  localparam int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [31:0] fuse_w   [ROWS];
  logic [31:0] shadow_w [ROWS];

  for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
    logic [31:0] f_q;
    logic [31:0] s_q;
    logic        hit;

    assign hit = burn_en && (burn_row == 8'(gr));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= '0;
        s_q <= '0;
      end else begin
        if (hit)       f_q <= f_q | burn_data;
        if (reload_en) s_q <= f_q;
      end
    end

    assign fuse_w[gr]   = f_q;
    assign shadow_w[gr] = s_q;

    AST_FUSE_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (f_q & $past(f_q)) == $past(f_q));  // R6

    if (WR_LOCK[gr]) begin : g_lk
      AST_WR_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(f_q));  // R9
    end
  end

  logic              rd_in;
  logic              pr_in;
  logic [RIDX_W-1:0] rd_idx;
  logic [RIDX_W-1:0] pr_idx;

  assign rd_in  = int'(rd_row) < ROWS;
  assign pr_in  = int'(prog_row) < ROWS;
  assign rd_idx = rd_in ? rd_row[RIDX_W-1:0] : '0;
  assign pr_idx = pr_in ? prog_row[RIDX_W-1:0] : '0;

  assign rd_word   = rd_in ? shadow_w[rd_idx] : '0;
  assign rd_locked = rd_in && RD_LOCK[rd_idx];
  assign prog_ok   = pr_in && !WR_LOCK[pr_idx];

  AST_BURN_TARGET_OK: assert property (@(posedge clk) disable iff (!rst_n)
    burn_en |-> (int'(burn_row) < ROWS));  // R9

endmodule

// File: rtl/fuse_regif.sv
module fuse_regif #(
  parameter int              ROWS       = 16,
  parameter int              BUS_AW     = 13,
  parameter logic [ROWS-1:0] RD_LOCK    = ROWS'(32'h0000_0008),
  parameter logic [ROWS-1:0] WR_LOCK    = ROWS'(32'h0000_0020),
  parameter logic [27:0]     TIMING_RST = 28'h543_1008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  import fuse_pkg::*;

  localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(OFS_CTRL);
  localparam logic [BUS_AW-1:0] A_SET  = BUS_AW'(OFS_SET);
  localparam logic [BUS_AW-1:0] A_CLR  = BUS_AW'(OFS_CLR);
  localparam logic [BUS_AW-1:0] A_TIM  = BUS_AW'(OFS_TIMING);
  localparam logic [BUS_AW-1:0] A_DATA = BUS_AW'(OFS_DATA);
  localparam logic [BUS_AW-1:0] A_SHW  = BUS_AW'(OFS_SHADOW);

  // register state
  logic [7:0]  row_q;
  logic        err_q;
  logic        reload_q;
  logic        armed_q;
  logic        mode_reload_q;
  logic [27:0] timing_q;
  logic [31:0] data_q;

  // named events
  logic wr_ctrl, wr_set, wr_clr, wr_tim, wr_data, any_wr;
  logic seq_busy, seq_done, seq_start;
  logic wr_blocked, wr_ok;
  logic key_ok, launch_burn, lock_fail, reload_req;
  logic commit_burn, commit_reload;
  logic prog_ok;
  logic [CNT_W-1:0] seq_len;

  // shadow window decode
  logic [BUS_AW-1:0] shw_off;
  logic              shw_hit;
  logic [7:0]        shw_row;
  logic [31:0]       shw_word;
  logic              shw_locked;
  logic              rd_poison;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_set  = bus_wr && (bus_addr == A_SET);
  assign wr_clr  = bus_wr && (bus_addr == A_CLR);
  assign wr_tim  = bus_wr && (bus_addr == A_TIM);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign any_wr  = wr_ctrl || wr_set || wr_clr || wr_tim || wr_data;

  assign wr_blocked = seq_busy && any_wr;
  assign wr_ok      = !seq_busy;

  assign key_ok      = (bus_wdata[31:16] == UNLOCK_KEY);
  assign launch_burn = wr_ok && wr_data && armed_q && prog_ok;
  assign lock_fail   = wr_ok && wr_data && armed_q && !prog_ok;
  assign reload_req  = wr_ok && (wr_ctrl || wr_set) && bus_wdata[BIT_RELOAD];

  assign seq_start = launch_burn || reload_req;
  assign seq_len   = launch_burn ? burn_len(timing_q[11:0], timing_q[15:12])
                                 : reload_len(timing_q[21:16]);

  assign commit_burn   = seq_done && !mode_reload_q;
  assign commit_reload = seq_done && mode_reload_q;

  assign shw_off  = bus_addr - A_SHW;
  assign shw_hit  = (bus_addr >= A_SHW) && (shw_off[3:0] == 4'h0) &&
                    (int'(shw_off[BUS_AW-1:4]) < ROWS);
  assign shw_row  = shw_hit ? 8'(shw_off[BUS_AW-1:4]) : 8'h00;
  assign rd_poison = bus_rd && shw_hit && shw_locked;

  fuse_seq #(.CNT_W(CNT_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (seq_start),
    .len   (seq_len),
    .busy  (seq_busy),
    .done  (seq_done)
  );

  fuse_store #(.ROWS(ROWS), .RD_LOCK(RD_LOCK), .WR_LOCK(WR_LOCK)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .burn_en   (commit_burn),
    .burn_row  (row_q),
    .burn_data (data_q),
    .reload_en (commit_reload),
    .prog_row  (row_q),
    .prog_ok   (prog_ok),
    .rd_row    (shw_row),
    .rd_word   (shw_word),
    .rd_locked (shw_locked)
  );

  // control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q         <= '0;
      reload_q      <= 1'b0;
      armed_q       <= 1'b0;
      mode_reload_q <= 1'b0;
    end else begin
      if (wr_ok && wr_ctrl) begin
        row_q   <= bus_wdata[7:0];
        armed_q <= key_ok;
      end else if (wr_ok && wr_set) begin
        row_q <= row_q | bus_wdata[7:0];
      end else if (wr_ok && wr_clr) begin
        row_q <= row_q & ~bus_wdata[7:0];
      end else if (wr_ok && wr_data) begin
        armed_q <= 1'b0;
      end
      if (reload_req)         reload_q <= 1'b1;
      else if (commit_reload) reload_q <= 1'b0;
      if (seq_start) mode_reload_q <= reload_req;
    end
  end

  // error flag: hardware sets win, software clears through the clear alias
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (wr_blocked || lock_fail || rd_poison) begin
      err_q <= 1'b1;
    end else if (wr_ok && wr_clr && bus_wdata[BIT_ERR]) begin
      err_q <= 1'b0;
    end
  end

  // timing and data words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= TIMING_RST;
      data_q   <= '0;
    end else begin
      if (wr_ok && wr_tim)  timing_q <= timing_merge(timing_q, bus_wdata);
      if (wr_ok && wr_data) data_q   <= bus_wdata;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL || bus_addr == A_SET || bus_addr == A_CLR) begin
      bus_rdata = {21'h0, reload_q, err_q, seq_busy, row_q};
    end else if (bus_addr == A_TIM) begin
      bus_rdata = {4'h0, timing_q};
    end else if (bus_addr == A_DATA) begin
      bus_rdata = data_q;
    end else if (shw_hit) begin
      bus_rdata = shw_locked ? POISON : shw_word;
    end
  end

  AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> err_q);  // R10
  AST_TIMING_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> $stable(timing_q));  // R10
  AST_KEY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_data) |=> !armed_q);  // R4
  AST_RELOAD_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q |-> seq_busy);  // R7
  AST_POISON_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_poison |=> err_q);  // R8
  AST_LOCK_FAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fail |=> (err_q && !seq_busy));  // R9

endmodule

// File: tb/fuse_regif_tb.sv
module fuse_regif_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fuse_regif u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  function automatic int exp_burn(input int p, input int r);
    return r + p + r + 1;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic count_busy(input bit need_reload, output int n);
    logic [31:0] c;
    n = 0;
    for (int i = 0; i < 6000; i++) begin
      rd(13'h000, c);
      if (c[8] && (!need_reload || c[10])) n++;
      else break;
    end
  endtask

  task automatic burn(input logic [7:0] row, input logic [31:0] d);
    int n;
    wr(13'h000, {16'h3E77, 8'h00, row});
    wr(13'h020, d);
    count_busy(1'b0, n);
  endtask

  task automatic reload();
    int n;
    wr(13'h004, 32'h0000_0400);
    count_busy(1'b1, n);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(13'h000, v); check("R1 ctrl after reset", v, 32'h0);
    rd(13'h400, v); check("R1 shadow0 after reset", v, 32'h0);
    rd(13'h4F0, v); check("R1 shadow15 after reset", v, 32'h0);
    rd(13'h010, v); check("R3 timing reset value", v, 32'h0543_1008);
  endtask

  task automatic t_aliases();
    logic [31:0] v;
    wr(13'h000, 32'h0000_0012); rd(13'h000, v); check("R2 plain write row", v, 32'h12);
    wr(13'h004, 32'h0000_0021); rd(13'h000, v); check("R2 set alias", v, 32'h33);
    wr(13'h008, 32'h0000_0003); rd(13'h000, v); check("R2 clear alias", v, 32'h30);
    wr(13'h000, 32'hFFFF_0244); rd(13'h000, v); check("R2 high bits zero, error not writable", v, 32'h44);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    wr(13'h010, 32'hFFFF_FFFF); rd(13'h010, v); check("R3 all-ones write keeps 27:22", v, 32'h057F_FFFF);
    wr(13'h010, 32'h0004_2005); rd(13'h010, v); check("R3 field write", v, 32'h0544_2005);
  endtask

  task automatic t_burn_and_reload();
    logic [31:0] v;
    int n;
    wr(13'h000, 32'h3E77_0002); rd(13'h000, v); check("R4 key reads as zero", v, 32'h2);
    wr(13'h020, 32'h0F0F_0000);
    count_busy(1'b0, n); check("R5 burn busy length", 32'(n), 32'(exp_burn(5, 2)));
    rd(13'h420, v); check("R6 shadow unchanged before reload", v, 32'h0);
    wr(13'h004, 32'h0000_0400);
    count_busy(1'b1, n); check("R7 reload busy length", 32'(n), 32'(4 + 1));
    rd(13'h000, v); check("R7 reload bit clears", {21'h0, v[10:8], 8'h0}, 32'h0);
    rd(13'h420, v); check("R6 shadow after reload", v, 32'h0F0F_0000);
    burn(8'h02, 32'h0000_00FF);
    burn(8'h02, 32'h0000_0000);
    reload();
    rd(13'h420, v); check("R6 burns only set bits", v, 32'h0F0F_00FF);
  endtask

  task automatic t_no_key();
    logic [31:0] v;
    wr(13'h020, 32'h1111_1111);
    rd(13'h000, v); check("R4 data without key no busy", {31'h0, v[8]}, 32'h0);
    wr(13'h000, 32'h3E77_0004);
    wr(13'h000, 32'h0000_0004);
    wr(13'h020, 32'hAAAA_AAAA);
    rd(13'h000, v); check("R4 disarmed by plain write", {31'h0, v[8]}, 32'h0);
    reload();
    rd(13'h440, v); check("R4 row4 untouched", v, 32'h0);
  endtask

  task automatic t_wr_lock();
    logic [31:0] v;
    wr(13'h000, 32'h3E77_0005);
    wr(13'h020, 32'h0000_FFFF);
    rd(13'h000, v); check("R9 locked row: error set, no busy", {22'h0, v[9:8]}, 32'h2);
    wr(13'h020, 32'h0000_FFFF);
    rd(13'h000, v); check("R9 key consumed after failure", {31'h0, v[8]}, 32'h0);
    reload();
    rd(13'h450, v); check("R9 locked row fuses unchanged", v, 32'h0);
    wr(13'h008, 32'h0000_0200);
    rd(13'h000, v); check("R2 error cleared by clear alias", {31'h0, v[9]}, 32'h0);
    wr(13'h000, 32'h3E77_0014);
    wr(13'h020, 32'h0000_0001);
    rd(13'h000, v); check("R9 row beyond array sets error", {22'h0, v[9:8]}, 32'h2);
    wr(13'h008, 32'h0000_0200);
  endtask

  task automatic t_rd_lock();
    logic [31:0] v;
    burn(8'h03, 32'h0000_1234);
    reload();
    rd(13'h000, v); check("R8 error clear before read", {31'h0, v[9]}, 32'h0);
    rd(13'h430, v); check("R8 locked shadow poison", v, 32'hBADA_BADA);
    rd(13'h000, v); check("R8 locked read sets error", {31'h0, v[9]}, 32'h1);
    wr(13'h008, 32'h0000_0200);
  endtask

  task automatic t_busy_collide();
    logic [31:0] v;
    wr(13'h000, 32'h3E77_0001);
    wr(13'h020, 32'h8000_0001);
    wr(13'h010, 32'h0000_0000);
    for (int i = 0; i < 12; i++) begin
      rd(13'h410, v); check("R6 shadow stable across burn commit", v, 32'h0);
    end
    rd(13'h010, v); check("R10 timing write ignored while busy", v, 32'h0544_2005);
    rd(13'h000, v); check("R10 busy write sets error", {31'h0, v[9]}, 32'h1);
    wr(13'h008, 32'h0000_0200);
    reload();
    rd(13'h410, v); check("R6 burn visible after reload", v, 32'h8000_0001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_aliases();
    t_timing();
    t_burn_and_reload();
    t_no_key();
    t_wr_lock();
    t_rd_lock();
    t_busy_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule